// File: doc/BRIEF.md
# Framed Half-Word Link Port

This block is one end of a point-to-point synchronous link that carries 16 bits per transfer. A role bit picks the direction. As a sender, the port takes 32-bit words from its outgoing queue and puts each one on the link as two half-words, lower half first. As a receiver, it pairs incoming half-words back into 32-bit words and queues them for the processor. The processor writes words into the outgoing queue and reads words from the incoming queue. It can flush either queue with a one-cycle clear pulse.

A frame interrupt lets a DMA engine move whole frames. The programmed frame length is 1 to 255 words. The interrupt is a single pulse when a full frame can be moved: enough words have arrived (receiver), or enough free space exists (sender). The pulse then stays quiet until the queue has been drained or cleared. This prevents the repeated edges that raw queue flags would produce during one transfer.

A status word reports the queue levels, the current role and the link-rate select. A suspend input from the far end holds the sender between half-words.

Top module: `halfword_link_port`

## Requirements
- R1: After reset both queues are empty, the role is receiver, `lk_valid_o` and `irq` are 0, the input-level field reads 0 and the output-space field reads 255.
- R2: The role register copies `xmit_mode` (1 = sender) on each clock edge while `link_run` is 0. While `link_run` is 1, changes on `xmit_mode` have no effect, and a receiver never raises `lk_valid_o`.
- R3: As sender with `link_run` high and no suspend, each queued word leaves as two valid half-words on consecutive active cycles: bits 15:0 first, then bits 31:16, in queue order.
- R4: While `lk_suspend_i` is sampled high, the sender emits nothing on the next cycle. A half-word still owed is kept and sent after the suspend ends, so no data is lost.
- R5: As receiver with `link_run` high, each valid half-word is captured. The first half of a pair is bits 15:0 and the second is bits 31:16, and the word is queued when the second half arrives. A lone trailing half is held and not queued.
- R6: `status[31:24]` is the number of words in the input queue, saturated at 255. `status[23:16]` is the free space in the output queue, saturated at 255. `status[1]` is the role, `status[0]` is the registered rate select, and all other bits are 0.
- R7: `clr_in` empties the input queue and discards any held half-word. `clr_out` empties the output queue and drops any owed high half.
- R8: When the frame logic is armed and the threshold is met, `irq` pulses high for exactly one cycle and the logic disarms. The threshold for a receiver is input words >= `frame_len`; for a sender it is output free space >= `frame_len`.
- R9: The frame logic re-arms only when the active queue goes from non-empty to empty, or on a clear. A `frame_len` of 0 never raises `irq`.
- R10: `rate_fast_o` follows `clk_sel` one cycle later, at any time, whatever the role or run state.
- R11: A write to a full output queue is ignored. The queue holds 256 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xmit_mode | input | 1 | Requested role, 1 = sender |
| link_run | input | 1 | Link clock running; locks the role |
| clk_sel | input | 1 | Link rate select |
| frame_len | input | 8 | Frame length in words, 0 disables the interrupt |
| wr_en | input | 1 | Push `wr_data` into the output queue |
| wr_data | input | 32 | Word to send |
| rd_en | input | 1 | Pop the input queue |
| rd_data | output | 32 | Head of the input queue |
| clr_in | input | 1 | Flush the input queue |
| clr_out | input | 1 | Flush the output queue |
| status | output | 32 | Levels, role and rate select |
| irq | output | 1 | One-cycle frame pulse |
| rate_fast_o | output | 1 | Registered rate select |
| lk_valid_o | output | 1 | Outgoing half-word valid |
| lk_data_o | output | 16 | Outgoing half-word |
| lk_suspend_i | input | 1 | Far end asks the sender to pause |
| lk_valid_i | input | 1 | Incoming half-word valid |
| lk_data_i | input | 16 | Incoming half-word |

## Verification
A wrong half-pair phase shows up at once as swapped or shifted halves, either in the captured link stream or in the words read back. A held half that leaks through appears on the next word read after a clear. A bad arm state becomes visible as a wrong count of interrupt pulses within a few cycles of a queue crossing its threshold or draining. Role or suspend faults show as link activity in a cycle where none is allowed.

// File: rtl/halfword_link_port.sv
module halfword_link_port #(
  parameter int WORD_W = 32,
  parameter int HALF_W = 16,
  parameter int AW     = 8,
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xmit_mode,
  input  logic              link_run,
  input  logic              clk_sel,
  input  logic [FLAG_W-1:0] frame_len,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  input  logic              clr_in,
  input  logic              clr_out,
  output logic [WORD_W-1:0] status,
  output logic              irq,
  output logic              rate_fast_o,
  output logic              lk_valid_o,
  output logic [HALF_W-1:0] lk_data_o,
  input  logic              lk_suspend_i,
  input  logic              lk_valid_i,
  input  logic [HALF_W-1:0] lk_data_i
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = AW + 1;
  localparam int FMAX  = (1 << FLAG_W) - 1;

  logic [WORD_W-1:0] in_mem  [DEPTH];
  logic [WORD_W-1:0] out_mem [DEPTH];
  logic [AW-1:0] in_wp, in_rp, out_wp, out_rp;
  logic [CW-1:0] in_cnt, out_cnt, in_nx, out_nx, out_free;
  logic role_tx, rx_half, tx_hi_pend, armed;
  logic [HALF_W-1:0] rx_lo, tx_hi;

  wire rx_ok    = !role_tx && link_run && lk_valid_i;
  wire in_push  = rx_ok && rx_half && (in_cnt != CW'(DEPTH)) && !clr_in;
  wire in_pop   = rd_en && (in_cnt != '0) && !clr_in;
  wire out_push = wr_en && (out_cnt != CW'(DEPTH)) && !clr_out;
  wire tx_go    = role_tx && link_run && !lk_suspend_i && !clr_out &&
                  (tx_hi_pend || out_cnt != '0);
  wire out_pop  = tx_go && !tx_hi_pend;

  assign in_nx    = clr_in  ? '0 : in_cnt  + CW'(in_push)  - CW'(in_pop);
  assign out_nx   = clr_out ? '0 : out_cnt + CW'(out_push) - CW'(out_pop);
  assign out_free = CW'(DEPTH) - out_cnt;
  assign rd_data  = in_mem[in_rp];

  wire [FLAG_W-1:0] in_flag  = (int'(in_cnt)   > FMAX) ? FLAG_W'(FMAX) : in_cnt[FLAG_W-1:0];
  wire [FLAG_W-1:0] out_flag = (int'(out_free) > FMAX) ? FLAG_W'(FMAX) : out_free[FLAG_W-1:0];
  assign status = {in_flag, out_flag, {(WORD_W-2*FLAG_W-2){1'b0}}, role_tx, rate_fast_o};

  wire hit   = (frame_len != '0) &&
               (role_tx ? int'(out_free) >= int'(frame_len) : int'(in_cnt) >= int'(frame_len));
  wire rearm = clr_in || clr_out ||
               (role_tx ? (out_nx == '0 && out_cnt != '0) : (in_nx == '0 && in_cnt != '0));
  wire fire  = armed && hit;

  always_ff @(posedge clk) begin
    if (in_push)  in_mem[in_wp]   <= {lk_data_i, rx_lo};
    if (out_push) out_mem[out_wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_wp <= '0; in_rp <= '0; in_cnt <= '0;
      out_wp <= '0; out_rp <= '0; out_cnt <= '0;
      role_tx <= 1'b0; rx_half <= 1'b0; rx_lo <= '0;
      tx_hi_pend <= 1'b0; tx_hi <= '0;
      lk_valid_o <= 1'b0; lk_data_o <= '0;
      armed <= 1'b1; irq <= 1'b0; rate_fast_o <= 1'b0;
    end else begin
      rate_fast_o <= clk_sel;
      if (!link_run) role_tx <= xmit_mode;
      in_cnt  <= in_nx;
      out_cnt <= out_nx;
      if (clr_in) begin
        in_wp <= '0; in_rp <= '0; rx_half <= 1'b0;
      end else begin
        if (in_push) in_wp <= in_wp + 1'b1;
        if (in_pop)  in_rp <= in_rp + 1'b1;
        if (rx_ok) begin
          rx_half <= !rx_half;
          if (!rx_half) rx_lo <= lk_data_i;
        end
      end
      if (clr_out) begin
        out_wp <= '0; out_rp <= '0; tx_hi_pend <= 1'b0;
      end else begin
        if (out_push) out_wp <= out_wp + 1'b1;
        if (out_pop)  out_rp <= out_rp + 1'b1;
      end
      lk_valid_o <= tx_go;
      if (tx_go) begin
        if (tx_hi_pend) begin
          lk_data_o  <= tx_hi;
          tx_hi_pend <= 1'b0;
        end else begin
          lk_data_o  <= out_mem[out_rp][HALF_W-1:0];
          tx_hi      <= out_mem[out_rp][WORD_W-1:HALF_W];
          tx_hi_pend <= 1'b1;
        end
      end
      irq   <= fire;
      armed <= fire ? 1'b0 : (rearm ? 1'b1 : armed);
    end
  end

  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq);
  // R4
  suspend_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) lk_suspend_i |=> !lk_valid_o);
  // R2
  role_lock_chk: assert property (@(posedge clk) disable iff (!rst_n) link_run |=> $stable(role_tx));
  // R2
  rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !role_tx |=> !lk_valid_o);
  // R7
  clr_in_chk: assert property (@(posedge clk) disable iff (!rst_n) clr_in |=> in_cnt == '0);
  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cnt <= CW'(DEPTH)) && (out_cnt <= CW'(DEPTH)));
endmodule

// File: tb/test_halfword_link_port.sv
module test_halfword_link_port;
  logic clk = 0, rst_n = 0;
  logic xmit_mode = 0, link_run = 0, clk_sel = 0, wr_en = 0, rd_en = 0;
  logic clr_in = 0, clr_out = 0, lk_suspend_i = 0, lk_valid_i = 0;
  logic [7:0] frame_len = 0;
  logic [31:0] wr_data = 0, rd_data, status;
  logic [15:0] lk_data_i = 0, lk_data_o;
  logic irq, rate_fast_o, lk_valid_o;
  int checks = 0, errors = 0, irq_n = 0, cap_n = 0;
  logic [15:0] cap [0:1023];

  always #2 clk = ~clk;

  halfword_link_port i_halfword_link_port (.*);

  always @(posedge clk) begin
    if (irq) irq_n <= irq_n + 1;
    if (lk_valid_o && cap_n < 1024) begin cap[cap_n] <= lk_data_o; cap_n <= cap_n + 1; end
  end

  function automatic logic [31:0] rw(int i); return 32'h0F1E2D3C + i * 32'h01010203; endfunction
  function automatic logic [31:0] tw(int i); return (i * 32'h00010001) ^ 32'h5A5AA5A5; endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic send_half(logic [15:0] h);
    @(negedge clk); lk_valid_i = 1; lk_data_i = h;
    @(negedge clk); lk_valid_i = 0;
  endtask

  task automatic send_word(logic [31:0] w);
    send_half(w[15:0]); send_half(w[31:16]);
  endtask

  task automatic write_word(logic [31:0] w);
    @(negedge clk); wr_en = 1; wr_data = w;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic read_words(int base, int n, string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); chk(req, rd_data, rw(base + k)); rd_en = 1;
      @(negedge clk); rd_en = 0;
    end
  endtask

  task automatic pulse_clr(bit inq);
    @(negedge clk); if (inq) clr_in = 1; else clr_out = 1;
    @(negedge clk); clr_in = 0; clr_out = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c0;
    cyc(3); rst_n = 1; cyc(1);
    // R1 reset state
    chk("R1", status, 32'h00FF0000);
    chk("R1", {lk_valid_o, irq}, 2'b00);

    // R5 R8 receive ten words, frame length 4
    frame_len = 4; link_run = 1;
    for (int i = 0; i < 10; i++) send_word(rw(i));
    cyc(3);
    chk("R6", status[31:24], 10);
    chk("R8", irq_n, 1);
    read_words(0, 10, "R5");
    cyc(2);
    chk("R6", status[31:24], 0);
    // R9 re-armed after drain
    for (int i = 10; i < 14; i++) send_word(rw(i));
    cyc(3);
    chk("R9", irq_n, 2);
    read_words(10, 4, "R5");

    // R5 odd trailing half held
    send_half(rw(20)[15:0]); cyc(3);
    chk("R5", status[31:24], 0);
    send_half(rw(20)[31:16]); cyc(2);
    chk("R5", status[31:24], 1);
    read_words(20, 1, "R5");
    // R7 clr_in drops held half
    send_half(16'hDEAD);
    pulse_clr(1);
    send_word(rw(21)); cyc(2);
    chk("R7", status[31:24], 1);
    read_words(21, 1, "R7");
    cyc(2);
    chk("R9", irq_n, 2);

    // R2 role locked while running
    xmit_mode = 1;
    write_word(tw(0)); write_word(tw(1));
    c0 = cap_n; cyc(8);
    chk("R2", cap_n, c0);
    chk("R2", status[1], 0);

    // R3 sender, role taken while stopped
    link_run = 0;
    for (int i = 2; i < 6; i++) write_word(tw(i));
    cyc(2);
    chk("R6", {status[1], status[23:16]}, {1'b1, 8'd250});
    chk("R8", irq_n, 3);
    c0 = cap_n; link_run = 1; cyc(20);
    chk("R3", cap_n - c0, 12);
    for (int i = 0; i < 6; i++) begin
      chk("R3", cap[c0 + 2*i], tw(i)[15:0]);
      chk("R3", cap[c0 + 2*i + 1], tw(i)[31:16]);
    end
    chk("R9", irq_n, 4);

    // R4 suspend
    link_run = 0;
    for (int i = 6; i < 9; i++) write_word(tw(i));
    lk_suspend_i = 1; link_run = 1; c0 = cap_n; cyc(10);
    chk("R4", cap_n, c0);
    for (int j = 0; j < 30; j++) begin @(negedge clk); lk_suspend_i = (j % 3 != 0); end
    lk_suspend_i = 0; cyc(12);
    chk("R4", cap_n - c0, 6);
    for (int i = 0; i < 3; i++) begin
      chk("R4", cap[c0 + 2*i], tw(6 + i)[15:0]);
      chk("R4", cap[c0 + 2*i + 1], tw(6 + i)[31:16]);
    end
    chk("R9", irq_n, 5);

    // R7 clr_out, R9 frame_len 0
    frame_len = 0; link_run = 0;
    write_word(tw(50)); write_word(tw(51));
    pulse_clr(0);
    chk("R7", status[23:16], 8'd255);
    c0 = cap_n; link_run = 1; cyc(10);
    chk("R7", cap_n, c0);
    chk("R9", irq_n, 5);

    // R10 rate select
    @(negedge clk); clk_sel = 1; cyc(1);
    chk("R10", {rate_fast_o, status[0]}, 2'b11);
    clk_sel = 0; cyc(1);
    chk("R10", rate_fast_o, 0);

    // R11 full output queue
    link_run = 0;
    for (int i = 0; i < 257; i++) write_word(tw(100 + i));
    chk("R11", status[23:16], 0);
    c0 = cap_n; link_run = 1; cyc(560);
    chk("R11", cap_n - c0, 512);
    chk("R11", cap[c0], tw(100)[15:0]);
    chk("R11", cap[c0 + 511], tw(355)[31:16]);
    chk("R9", irq_n, 5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule